// File: doc/BRIEF.md
# Interrupt Controller Command Register Port

This block is the byte-wide command and status port of a single eight-line interrupt controller. A host writes and reads two addresses. Writes carry a multi-word initialization sequence, mask updates, end-of-interrupt and priority-rotation commands, and read-selection and poll commands. Reads return the pending-request register, the in-service register, the mask register, or a poll byte. Edge-triggered request lines are captured internally. A rotating-priority resolver compares the best unmasked request with the highest line in service and raises `int_req` when that request should interrupt.

A downstream vector unit, which lies outside this block, observes `int_req`, `int_line`, `vec_base` and the mode outputs. It pulses `ack` to accept the current winner. Cascading between controllers is not part of this block. Special fully nested mode is only stored and presented on an output for that neighbour.

Top module: `pic_cmd_port`

## Requirements
- R1: After reset, mask, request and in-service registers, rotation offset and base vector are zero, `int_req` and `init_err` are low, and address 0 reads the request register.
- R2: A write to address 0 with bit 4 set starts initialization. It clears mask, request, in-service, rotation offset, base vector, read select, poll, special mask, auto-EOI, rotate-on-auto-EOI and nested-mode state, and it records bit 0 as "mode word follows". Edge history is also cleared, so a line held high is captured again one cycle later.
- R3: That start word sets `init_err` if bit 1 (single mode) or bit 3 (level mode) is set, and clears it otherwise.
- R4: After the start word, address-1 writes are consumed in order: the first sets `vec_base` to the byte with bits 2:0 cleared, the second is discarded, and a third is taken only when requested, setting nested mode from bit 4 and auto-EOI from bit 1. None of these writes touch the mask.
- R5: Outside initialization, an address-1 write loads the mask, and a non-poll read of address 1 returns it.
- R6: A rising edge on `irq_in[i]` sets request bit i. Priority runs from line offset upward, wrapping modulo 8. `int_req` is high when the best unmasked request ranks strictly above the best in-service line, and `int_line` gives that request.
- R7: An address-0 write with bit 4 clear and bit 3 set is a select word. When bit 1 is set, bit 0 chooses in-service (1) or request (0) for address-0 reads. Bit 2 arms a poll.
- R8: In the select word, bit 6 enables loading special-mask mode from bit 5. In that mode, in-service lines that are masked do not block requests.
- R9: When `ack` is high and `int_req` is high, with no write or poll read in the same cycle, the winner's request bit clears. Its in-service bit sets unless auto-EOI is on. With auto-EOI and rotate-on-auto-EOI both on, the offset becomes line+1.
- R10: Otherwise an address-0 write is a priority word with command bits 7:5. Command 1 clears the highest-priority in-service bit. Command 5 does the same and sets the offset to that line+1.
- R11: Command 3 clears in-service bit [2:0]. Command 7 also sets the offset to that line+1. Command 6 sets the offset to ([2:0]+1) mod 8. Commands 0 and 4 set rotate-on-auto-EOI to command bit 2.
- R12: While a poll is armed, reads of either address return 0x80 OR the winning line, or 0x00 when none. A read clears the winner's request and in-service bits and disarms the poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NLINES | Edge-triggered request lines |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effect only in poll) |
| addr | input | 1 | Register address |
| wdata | input | 8 | Write byte |
| ack | input | 1 | Acceptance of current winner |
| rdata | output | 8 | Read byte |
| int_req | output | 1 | Interrupt request to the host |
| int_line | output | log2(NLINES) | Winning request line |
| vec_base | output | 8 | Base vector |
| aeoi_mode | output | 1 | Auto-EOI enabled |
| sfnm_mode | output | 1 | Special fully nested mode |
| init_err | output | 1 | Unsupported mode requested |

## Verification
The bench targets nested priority, where a newer high line must pre-empt and a lower one must wait behind in-service lines. A resolver that ignored in-service state would raise the lower request too early. Rotation is exercised through commands 5, 6 and 7 and through the auto-EOI path; an off-by-one offset shows up as the wrong winner on the next pair of requests. Poll reads with and without a pending line, the init sequence with and without a mode word, and special-mask unblocking are covered. A design that leaves poll armed, or that lets init words reach the mask, would return the wrong byte on the next read.

// File: rtl/pic_port_pkg.sv
`timescale 1ns/1ps
package pic_port_pkg;

   typedef enum logic [2:0] {
      OP_IDLE,
      OP_START,
      OP_SELECT,
      OP_PRIO,
      OP_SETUP,
      OP_MASK
   } port_op_e;

   typedef enum logic [1:0] {
      IS_RUN,
      IS_BASE,
      IS_CASC,
      IS_MODE
   } init_st_e;

   typedef struct packed {
      port_op_e   op;
      logic [2:0] cmd;
      logic [2:0] tgt;
   } port_cmd_t;

endpackage

// File: rtl/pic_cmd_decode.sv
`timescale 1ns/1ps
module pic_cmd_decode
   import pic_port_pkg::*;
(
   input  logic       wr_en,
   input  logic       addr,
   input  logic [7:0] wdata,
   input  logic       in_init,
   output port_cmd_t  pc
);

   always_comb begin
      pc.cmd = wdata[7:5];
      pc.tgt = wdata[2:0];
      if (!wr_en)
         pc.op = OP_IDLE;
      else if (!addr) begin
         if (wdata[4])
            pc.op = OP_START;
         else if (wdata[3])
            pc.op = OP_SELECT;
         else
            pc.op = OP_PRIO;
      end else
         pc.op = in_init ? OP_SETUP : OP_MASK;
   end

endmodule

// File: rtl/pic_rot_prio.sv
`timescale 1ns/1ps
module pic_rot_prio #(
   parameter int N = 8,
   localparam int LW = $clog2(N)
)(
   input  logic [N-1:0]  mask,
   input  logic [LW-1:0] rot,
   output logic          found,
   output logic [LW-1:0] rank
);

   logic [N-1:0] rotated;

   for (genvar g = 0; g < N; g++) begin : g_rot
      assign rotated[g] = mask[LW'(g) + rot];
   end

   always_comb begin
      rank = '0;
      for (int i = N - 1; i >= 0; i--)
         if (rotated[i]) rank = LW'(i);
   end

   assign found = |mask;

endmodule

// File: rtl/pic_req_capture.sv
`timescale 1ns/1ps
module pic_req_capture #(
   parameter int N = 8
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lines,
   input  logic [N-1:0] clr,
   input  logic         flush,
   output logic [N-1:0] irr
);

   logic [N-1:0] last_q;
   logic [N-1:0] edges;

   assign edges = lines & ~last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr    <= '0;
         last_q <= '0;
      end else if (flush) begin
         irr    <= '0;
         last_q <= '0;
      end else begin
         irr    <= (irr & ~clr) | edges;
         last_q <= lines;
      end
   end

   // R6
   edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|edges) && !flush |=> ((irr & $past(edges)) == $past(edges)));

endmodule

// File: rtl/pic_cmd_port.sv
`timescale 1ns/1ps
module pic_cmd_port
   import pic_port_pkg::*;
#(
   parameter int NLINES = 8,
   parameter int DW     = 8,
   localparam int LW    = $clog2(NLINES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] irq_in,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              addr,
   input  logic [DW-1:0]     wdata,
   input  logic              ack,
   output logic [DW-1:0]     rdata,
   output logic              int_req,
   output logic [LW-1:0]     int_line,
   output logic [DW-1:0]     vec_base,
   output logic              aeoi_mode,
   output logic              sfnm_mode,
   output logic              init_err
);

   localparam logic [DW-1:0] BASE_KEEP = ~DW'(NLINES - 1);
   localparam logic [DW-1:0] POLL_FLAG = DW'(1) << (DW - 1);

   initial begin
      assert (NLINES == 2 || NLINES == 4 || NLINES == 8)
         else $error("NLINES must be 2, 4 or 8");
      assert (DW == 8)
         else $error("DW must be 8");
   end

   logic [NLINES-1:0] imr_q, isr_q, irr_q;
   logic [LW-1:0]     rot_q;
   logic [DW-1:0]     base_q;
   logic              rsel_q, poll_q, smm_q, aeoi_q, raeoi_q, sfnm_q, need4_q, err_q;
   init_st_e          ist_q;

   port_cmd_t         pc;
   logic [LW-1:0]     tgt;
   logic              req_found, svc_found, eoi_found;
   logic [LW-1:0]     req_rank, svc_rank, eoi_rank;
   logic [LW-1:0]     win_line, eoi_line;
   logic [NLINES-1:0] req_mask, svc_mask, irr_clr, win_bit;
   logic              poll_fire, ack_fire;

   pic_cmd_decode u_dec (
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .in_init (ist_q != IS_RUN),
      .pc      (pc)
   );

   assign tgt      = pc.tgt[LW-1:0];
   assign req_mask = irr_q & ~imr_q;
   assign svc_mask = smm_q ? (isr_q & ~imr_q) : isr_q;

   pic_rot_prio #(.N(NLINES)) u_req (
      .mask (req_mask), .rot (rot_q), .found (req_found), .rank (req_rank));
   pic_rot_prio #(.N(NLINES)) u_svc (
      .mask (svc_mask), .rot (rot_q), .found (svc_found), .rank (svc_rank));
   pic_rot_prio #(.N(NLINES)) u_eoi (
      .mask (isr_q),    .rot (rot_q), .found (eoi_found), .rank (eoi_rank));

   assign win_line = req_rank + rot_q;
   assign eoi_line = eoi_rank + rot_q;
   assign int_req  = req_found && (!svc_found || (req_rank < svc_rank));
   assign win_bit  = NLINES'(1) << win_line;

   assign poll_fire = rd_en && !wr_en && poll_q;
   assign ack_fire  = ack && !wr_en && !poll_fire && int_req;
   assign irr_clr   = ((poll_fire && int_req) || ack_fire) ? win_bit : '0;

   pic_req_capture #(.N(NLINES)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .lines (irq_in),
      .clr   (irr_clr),
      .flush (pc.op == OP_START),
      .irr   (irr_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imr_q   <= '0;
         isr_q   <= '0;
         rot_q   <= '0;
         base_q  <= '0;
         rsel_q  <= 1'b0;
         poll_q  <= 1'b0;
         smm_q   <= 1'b0;
         aeoi_q  <= 1'b0;
         raeoi_q <= 1'b0;
         sfnm_q  <= 1'b0;
         need4_q <= 1'b0;
         err_q   <= 1'b0;
         ist_q   <= IS_RUN;
      end else begin
         unique case (pc.op)
            OP_START: begin
               imr_q   <= '0;
               isr_q   <= '0;
               rot_q   <= '0;
               base_q  <= '0;
               rsel_q  <= 1'b0;
               poll_q  <= 1'b0;
               smm_q   <= 1'b0;
               aeoi_q  <= 1'b0;
               raeoi_q <= 1'b0;
               sfnm_q  <= 1'b0;
               need4_q <= wdata[0];
               err_q   <= wdata[1] | wdata[3];
               ist_q   <= IS_BASE;
            end
            OP_SELECT: begin
               if (wdata[2]) poll_q <= 1'b1;
               if (wdata[1]) rsel_q <= wdata[0];
               if (wdata[6]) smm_q  <= wdata[5];
            end
            OP_PRIO: begin
               case (pc.cmd)
                  3'd0, 3'd4: raeoi_q <= pc.cmd[2];
                  3'd1, 3'd5: begin
                     if (eoi_found) begin
                        isr_q[eoi_line] <= 1'b0;
                        if (pc.cmd[2]) rot_q <= eoi_line + LW'(1);
                     end
                  end
                  3'd3, 3'd7: begin
                     isr_q[tgt] <= 1'b0;
                     if (pc.cmd[2]) rot_q <= tgt + LW'(1);
                  end
                  3'd6: rot_q <= tgt + LW'(1);
                  default: ;
               endcase
            end
            OP_SETUP: begin
               case (ist_q)
                  IS_BASE: begin
                     base_q <= wdata & BASE_KEEP;
                     ist_q  <= IS_CASC;
                  end
                  IS_CASC: ist_q <= need4_q ? IS_MODE : IS_RUN;
                  IS_MODE: begin
                     sfnm_q <= wdata[4];
                     aeoi_q <= wdata[1];
                     ist_q  <= IS_RUN;
                  end
                  default: ist_q <= IS_RUN;
               endcase
            end
            OP_MASK: imr_q <= wdata[NLINES-1:0];
            default: begin
               if (poll_fire) begin
                  poll_q <= 1'b0;
                  if (int_req) isr_q[win_line] <= 1'b0;
               end else if (ack_fire) begin
                  if (!aeoi_q)
                     isr_q[win_line] <= 1'b1;
                  else if (raeoi_q)
                     rot_q <= win_line + LW'(1);
               end
            end
         endcase
      end
   end

   always_comb begin
      if (poll_q)
         rdata = int_req ? (POLL_FLAG | DW'(win_line)) : '0;
      else if (addr)
         rdata = DW'(imr_q);
      else if (rsel_q)
         rdata = DW'(isr_q);
      else
         rdata = DW'(irr_q);
   end

   assign int_line  = win_line;
   assign vec_base  = base_q;
   assign aeoi_mode = aeoi_q;
   assign sfnm_mode = sfnm_q;
   assign init_err  = err_q;

   // R2
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !addr && wdata[4] |=> (imr_q == '0) && (isr_q == '0) && (irr_q == '0) && (ist_q == IS_BASE));

   // R3
   mode_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !addr && wdata[4] && (wdata[1] || wdata[3]) |=> init_err);

   // R11
   spec_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !addr && !wdata[4] && !wdata[3] && (wdata[7:5] == 3'd3)
      |=> !isr_q[$past(wdata[LW-1:0])]);

   // R9
   ack_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fire && !aeoi_q |=> isr_q[$past(win_line)]);

   // R12
   poll_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poll_fire |=> !poll_q);

endmodule

// File: tb/sim_pic_cmd_port.sv
`timescale 1ns/1ps
module sim_pic_cmd_port;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] irq_v = '0;
   logic       wr_v = 1'b0, rd_v = 1'b0, addr_v = 1'b0, ack_v = 1'b0;
   logic [7:0] wd_v = '0;
   logic [7:0] rdata;
   logic       int_req;
   logic [2:0] int_line;
   logic [7:0] vec_base;
   logic       aeoi_mode, sfnm_mode, init_err;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;
   string cur_req = "R1";

   // reference model state
   logic [7:0] m_irr, m_imr, m_isr, m_last, m_base;
   int         m_rot, m_init;
   bit         m_rsel, m_poll, m_smm, m_aeoi, m_raeoi, m_sfnm, m_need4, m_err;
   bit         m_ei;
   int         m_el;

   // samples taken before each edge
   logic [7:0] s_rd;
   logic       s_int;
   logic [2:0] s_line;

   always #2 clk = ~clk;

   pic_cmd_port u0 (
      .clk (clk), .rst_n (rst_n), .irq_in (irq_v), .wr_en (wr_v), .rd_en (rd_v),
      .addr (addr_v), .wdata (wd_v), .ack (ack_v), .rdata (rdata), .int_req (int_req),
      .int_line (int_line), .vec_base (vec_base), .aeoi_mode (aeoi_mode),
      .sfnm_mode (sfnm_mode), .init_err (init_err)
   );

   function automatic int mprio(logic [7:0] m, int off);
      for (int i = 0; i < 8; i++)
         if (m[(i + off) % 8]) return i;
      return 8;
   endfunction

   task automatic mreset();
      m_irr = 0; m_imr = 0; m_isr = 0; m_last = 0; m_base = 0; m_rot = 0; m_init = 0;
      m_rsel = 0; m_poll = 0; m_smm = 0; m_aeoi = 0; m_raeoi = 0; m_sfnm = 0;
      m_need4 = 0; m_err = 0;
   endtask

   task automatic chk(int act, int exp, string req, string what);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic cmp_all();
      int rp, sp;
      logic [7:0] erd;
      bit bad;
      rp = mprio(m_irr & ~m_imr, m_rot);
      sp = mprio(m_smm ? (m_isr & ~m_imr) : m_isr, m_rot);
      m_ei = rp < sp;
      m_el = (rp + m_rot) % 8;
      if (m_poll) erd = m_ei ? (8'h80 | 8'(m_el)) : 8'h00;
      else if (addr_v) erd = m_imr;
      else if (m_rsel) erd = m_isr;
      else erd = m_irr;
      bad = 0;
      compared++;
      if (rdata !== erd) begin
         bad = 1;
         $display("FAIL %s model rdata actual=0x%0h expected=0x%0h", cur_req, rdata, erd);
      end
      if (int_req !== m_ei) begin
         bad = 1;
         $display("FAIL %s model int_req actual=%0d expected=%0d", cur_req, int_req, m_ei);
      end
      if (m_ei && int_line !== 3'(m_el)) begin
         bad = 1;
         $display("FAIL %s model int_line actual=%0d expected=%0d", cur_req, int_line, m_el);
      end
      if (vec_base !== m_base || init_err !== m_err || aeoi_mode !== m_aeoi || sfnm_mode !== m_sfnm) begin
         bad = 1;
         $display("FAIL %s model modes actual=%h/%0d/%0d/%0d expected=%h/%0d/%0d/%0d", cur_req,
                  vec_base, init_err, aeoi_mode, sfnm_mode, m_base, m_err, m_aeoi, m_sfnm);
      end
      if (bad) mismatched++;
   endtask

   task automatic mupdate(bit w, bit r, bit a, logic [7:0] d, bit k);
      logic [7:0] clr, bitw;
      bit flush, pf, af;
      int cmd, e;
      clr = 0; flush = 0;
      bitw = 8'(1) << m_el;
      pf = r && !w && m_poll;
      af = k && !w && !pf && m_ei;
      if (w) begin
         if (!a && d[4]) begin
            m_imr = 0; m_isr = 0; m_rot = 0; m_base = 0; m_rsel = 0; m_poll = 0;
            m_smm = 0; m_aeoi = 0; m_raeoi = 0; m_sfnm = 0;
            m_need4 = d[0]; m_err = d[1] | d[3]; m_init = 1; flush = 1;
         end else if (!a && d[3]) begin
            if (d[2]) m_poll = 1;
            if (d[1]) m_rsel = d[0];
            if (d[6]) m_smm = d[5];
         end else if (!a) begin
            cmd = d[7:5];
            if (cmd == 0 || cmd == 4) m_raeoi = (cmd == 4);
            if (cmd == 1 || cmd == 5) begin
               e = mprio(m_isr, m_rot);
               if (e < 8) begin
                  e = (e + m_rot) % 8;
                  m_isr[e] = 0;
                  if (cmd == 5) m_rot = (e + 1) % 8;
               end
            end
            if (cmd == 3 || cmd == 7) begin
               m_isr[d[2:0]] = 0;
               if (cmd == 7) m_rot = (d[2:0] + 1) % 8;
            end
            if (cmd == 6) m_rot = (d[2:0] + 1) % 8;
         end else begin
            if (m_init == 1) begin m_base = d & 8'hF8; m_init = 2; end
            else if (m_init == 2) m_init = m_need4 ? 3 : 0;
            else if (m_init == 3) begin m_sfnm = d[4]; m_aeoi = d[1]; m_init = 0; end
            else m_imr = d;
         end
      end else if (pf) begin
         m_poll = 0;
         if (m_ei) begin m_isr = m_isr & ~bitw; clr = bitw; end
      end else if (af) begin
         clr = bitw;
         if (!m_aeoi) m_isr = m_isr | bitw;
         else if (m_raeoi) m_rot = (m_el + 1) % 8;
      end
      if (flush) begin
         m_irr = 0; m_last = 0;
      end else begin
         m_irr = (m_irr & ~clr) | (irq_v & ~m_last);
         m_last = irq_v;
      end
   endtask

   task automatic tick(bit w, bit r, bit a, logic [7:0] d, bit k);
      wr_v = w; rd_v = r; addr_v = a; wd_v = d; ack_v = k;
      #1;
      cmp_all();
      s_rd = rdata; s_int = int_req; s_line = int_line;
      @(posedge clk);
      mupdate(w, r, a, d, k);
      @(negedge clk);
      wr_v = 0; rd_v = 0; ack_v = 0;
   endtask

   task automatic wr(bit a, logic [7:0] d);
      tick(1, 0, a, d, 0);
   endtask

   task automatic look(bit a);
      tick(0, 0, a, 8'h00, 0);
   endtask

   task automatic pulse(logic [7:0] b);
      irq_v = irq_v | b;
      look(0);
      irq_v = irq_v & ~b;
      look(0);
   endtask

   task automatic do_ack();
      tick(0, 0, 0, 8'h00, 1);
   endtask

   initial begin
      mreset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      cur_req = "R1";
      look(0);
      chk(s_rd, 8'h00, "R1", "request read");
      chk(s_int, 0, "R1", "int_req");
      chk(init_err, 0, "R1", "init_err");
      chk(vec_base, 8'h00, "R1", "vec_base");
      look(1);
      chk(s_rd, 8'h00, "R1", "mask read");

      cur_req = "R4";
      wr(0, 8'h11);
      wr(1, 8'h4D);
      look(1);
      chk(s_rd, 8'h00, "R4", "mask after base word");
      chk(vec_base, 8'h48, "R4", "vec_base");
      wr(1, 8'h00);
      look(1);
      chk(s_rd, 8'h00, "R4", "mask after discarded word");
      wr(1, 8'h10);
      look(0);
      chk(sfnm_mode, 1, "R4", "nested mode");
      chk(aeoi_mode, 0, "R4", "auto-EOI");

      cur_req = "R5";
      wr(1, 8'hF0);
      look(1);
      chk(s_rd, 8'hF0, "R5", "mask readback");

      cur_req = "R6";
      pulse(8'h22);
      look(0);
      chk(s_int, 1, "R6", "int_req line1");
      chk(s_line, 1, "R6", "winner line1");
      chk(s_rd, 8'h22, "R7", "request register read");

      cur_req = "R9";
      do_ack();
      look(0);
      chk(s_int, 0, "R9", "no int after ack");
      wr(0, 8'h0B);
      look(0);
      chk(s_rd, 8'h02, "R9", "in-service after ack");

      cur_req = "R6";
      pulse(8'h01);
      look(0);
      chk(s_int, 1, "R6", "pre-empt by line0");
      chk(s_line, 0, "R6", "winner line0");
      pulse(8'h08);
      do_ack();
      look(0);
      chk(s_rd, 8'h03, "R9", "in-service lines 0,1");
      chk(s_int, 0, "R6", "line3 blocked");

      cur_req = "R10";
      wr(0, 8'h20);
      look(0);
      chk(s_rd, 8'h02, "R10", "non-specific EOI");
      cur_req = "R11";
      wr(0, 8'h61);
      look(0);
      chk(s_rd, 8'h00, "R11", "specific EOI");
      chk(s_line, 3, "R11", "line3 released");

      cur_req = "R7";
      wr(0, 8'h0A);
      look(0);
      chk(s_rd, 8'h28, "R7", "request select");

      cur_req = "R12";
      wr(0, 8'h0C);
      look(0);
      chk(s_rd, 8'h83, "R12", "poll byte");
      tick(0, 1, 0, 8'h00, 0);
      look(0);
      chk(s_rd, 8'h20, "R12", "after poll read");

      cur_req = "R8";
      wr(1, 8'h00);
      do_ack();
      pulse(8'h40);
      look(0);
      chk(s_int, 0, "R8", "line6 blocked by line5");
      wr(1, 8'h20);
      look(0);
      chk(s_int, 0, "R8", "mask without special mode");
      wr(0, 8'h68);
      look(0);
      chk(s_int, 1, "R8", "special mask unblocks");
      chk(s_line, 6, "R8", "winner line6");
      wr(0, 8'h48);
      look(0);
      chk(s_int, 0, "R8", "special mask off");
      wr(0, 8'h65);
      wr(1, 8'h00);
      do_ack();
      wr(0, 8'h66);

      cur_req = "R11";
      wr(0, 8'hC3);
      pulse(8'h44);
      look(0);
      chk(s_line, 6, "R11", "rotation set to 4");
      do_ack();
      cur_req = "R10";
      wr(0, 8'hA0);
      look(0);
      chk(s_line, 2, "R10", "rotating EOI winner");
      pulse(8'h82);
      look(0);
      chk(s_line, 7, "R10", "offset 7 winner");
      cur_req = "R11";
      wr(0, 8'hE7);
      look(0);
      chk(s_line, 1, "R11", "specific rotate winner");

      cur_req = "R3";
      wr(0, 8'h1B);
      look(1);
      chk(init_err, 1, "R3", "error flag");
      chk(s_rd, 8'h00, "R2", "mask cleared");
      look(0);
      chk(s_rd, 8'h00, "R2", "requests cleared");
      chk(s_int, 0, "R2", "int cleared");
      wr(0, 8'h11);
      look(0);
      chk(init_err, 0, "R3", "error cleared");
      cur_req = "R4";
      wr(1, 8'h20);
      wr(1, 8'h00);
      wr(1, 8'h02);
      look(0);
      chk(aeoi_mode, 1, "R4", "auto-EOI set");

      cur_req = "R9";
      wr(0, 8'h80);
      pulse(8'h04);
      do_ack();
      wr(0, 8'h0B);
      look(0);
      chk(s_rd, 8'h00, "R9", "auto-EOI keeps in-service clear");
      pulse(8'h14);
      look(0);
      chk(s_line, 4, "R9", "rotate on auto-EOI");
      cur_req = "R11";
      wr(0, 8'h00);
      do_ack();
      pulse(8'h08);
      look(0);
      chk(s_line, 3, "R11", "rotation frozen after cmd0");

      cur_req = "R12";
      do_ack();
      do_ack();
      wr(0, 8'h0C);
      look(0);
      chk(s_rd, 8'h00, "R12", "empty poll");
      tick(0, 1, 0, 8'h00, 0);

      cur_req = "R2";
      irq_v = 8'h01;
      look(0);
      wr(0, 8'h10);
      look(0);
      chk(s_rd, 8'h00, "R2", "flush on start");
      look(0);
      chk(s_rd, 8'h01, "R2", "held line recaptured");
      irq_v = 8'h00;
      cur_req = "R4";
      wr(1, 8'h08);
      wr(1, 8'h00);
      wr(1, 8'h55);
      look(1);
      chk(s_rd, 8'h55, "R4", "mask after short init");
      chk(aeoi_mode, 0, "R4", "auto-EOI cleared");
      chk(vec_base, 8'h08, "R4", "short init base");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         compared++;
         mismatched++;
         $display("FAIL %s watchdog actual=running expected=finished", cur_req);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule